// File: doc/BRIEF.md
# PLL Lock Detector Code Generator

This block turns a requested pixel clock frequency into the settings of a PLL frequency lock detector. The frequency arrives in hertz as a 32-bit number with a one-cycle `start` pulse. The block first picks a power-of-two pre-divider from the frequency band and scales the frequency down to kilohertz. It then forms a 9-bit target code by truncating division, a multiply by 24 and a rounding-up division. The three byte-wide register images it produces are ready to be written to the detector. Range checking of the request and the bus write of the images are left to the surrounding logic.

All three divisions run one after another on a single restoring shift-subtract divider that produces one quotient bit per cycle. A state machine steps through the divisions and holds `busy` for the whole computation. When the images are updated it drops `busy` and pulses `done` for one cycle. States: `ST_IDLE` (waits for start), `ST_KHZ_GO` / `ST_KHZ_RUN` (frequency divided by the pre-divider, then by 1000), `ST_TGT_GO` / `ST_TGT_RUN` (256,000,000 divided by the kHz value), `ST_CODE_GO` / `ST_CODE_RUN` (the product times 24, plus 999, divided by 1000) and `ST_PACK` (images written). Transitions: start in `ST_IDLE` goes to `ST_KHZ_GO`. Each `_GO` state goes to its `_RUN` state after one cycle. Each `_RUN` state leaves when the divider signals completion. `ST_PACK` returns to `ST_IDLE`.

Top module: `lkd_code_gen`

## Requirements
- R1: The pre-divider is 1 for 22,250,000..47,500,000 Hz, 2 for 50,349,650..99,000,000 Hz, 4 for 100,699,300..198,000,000 Hz and 8 for 205,000,000..297,000,000 Hz, all bounds inclusive. Any frequency outside these bands, including the gaps between them, uses 1. `div_reg[5:4]` holds log2 of the pre-divider and every other bit of `div_reg` is 0.
- R2: The kHz value is floor(floor(freq_hz / pre-divider) / 1000).
- R3: The target code is ceil((floor(256,000,000 / kHz) × 24) / 1000), kept to 9 bits.
- R4: `code_reg` holds code bits [7:0]. `ctl_reg[0]` holds code bit 8.
- R5: `ctl_reg[7:4]` is 2 (tolerance) and `ctl_reg[3:1]` is 2 (repeat code), so `ctl_reg` is 0x24 or 0x25.
- R6: A start sampled while idle raises `busy` on the next cycle. The images change only on the edge that raises `done`. `done` lasts exactly one cycle with `busy` low.
- R7: A start sampled while `busy` is high is ignored. The running computation finishes with the results of the frequency accepted first, and no extra `done` follows.
- R8: After reset, `busy`, `done` and all three images are 0.
- R9: `done` rises exactly 3×(W+2)+1 clock edges after the edge that samples start, where W is the data width (103 with the default 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| freq_hz | input | 32 | Requested pixel clock in Hz, captured with start |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the images are updated |
| div_reg | output | 8 | Pre-divider image, log2 in bits [5:4] |
| code_reg | output | 8 | Target code bits [7:0] |
| ctl_reg | output | 8 | Tolerance, repeat code and code bit 8 |

## Verification
The table drives every band edge, so an off-by-one band compare or a wrong shift shows up in `div_reg` and in the code. It also drives frequencies inside the gaps between bands, which separate the default pre-divider from a neighbouring band. The lowest frequency gives a code above 255, which exposes a lost or misplaced bit 8. A mid-band frequency whose product is not a multiple of 1000 shows whether the last division rounds up or truncates. The directed tests measure the exact latency and re-pulse start with a different frequency mid-run to show it is ignored.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KHZ_GO,
        ST_KHZ_RUN,
        ST_TGT_GO,
        ST_TGT_RUN,
        ST_CODE_GO,
        ST_CODE_RUN,
        ST_PACK
    } lkd_state_e;

    localparam int NUM_BANDS = 4;

    // Band limits in Hz, inclusive; band i selects a pre-divider of 2**i
    localparam logic [31:0] BAND_LO [NUM_BANDS] = '{
        32'd22_250_000, 32'd50_349_650, 32'd100_699_300, 32'd205_000_000
    };
    localparam logic [31:0] BAND_HI [NUM_BANDS] = '{
        32'd47_500_000, 32'd99_000_000, 32'd198_000_000, 32'd297_000_000
    };

    localparam int unsigned HZ_PER_KHZ   = 1000;
    localparam int unsigned TGT_NUMER    = 256_000_000;
    localparam int unsigned ROUND_ADD    = HZ_PER_KHZ - 1;
    localparam logic [3:0]  CTL_TOL      = 4'd2;
    localparam logic [2:0]  CTL_REPEAT   = 3'd2;
    localparam int          CODE_W       = 9;

endpackage

// File: rtl/lkd_band_sel.sv
module lkd_band_sel
    import lkd_pkg::*;
#(
    parameter int FW = 32
) (
    input  logic [FW-1:0] freq,
    output logic [1:0]    shift_log2
);

    logic [NUM_BANDS-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_BANDS; g++) begin : g_band
            assign hit[g] = (freq >= FW'(BAND_LO[g])) && (freq <= FW'(BAND_HI[g]));
        end
    endgenerate

    // Bands do not overlap; a miss falls back to a pre-divider of 1
    always_comb begin
        shift_log2 = 2'd0;
        for (int i = 0; i < NUM_BANDS; i++) begin
            if (hit[i]) begin
                shift_log2 = 2'(i);
            end
        end
    end

endmodule

// File: rtl/lkd_serial_div.sv
module lkd_serial_div #(
    parameter int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt_q;

    logic [W:0]    shifted;
    logic [W+1:0]  trial;
    logic [W-1:0]  rem_nx;
    logic [W-1:0]  quo_nx;

    // One restoring step: shift in the next dividend bit, try the subtract
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = {1'b0, shifted} - {2'b00, dsr_q};
        if (!trial[W+1]) begin
            rem_nx = trial[W-1:0];
            quo_nx = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_nx = shifted[W-1:0];
            quo_nx = {quo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem_q <= '0;
                quo_q <= dividend;
                dsr_q <= divisor;
                cnt_q <= CW'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

endmodule

// File: rtl/lkd_code_gen.sv
module lkd_code_gen
    import lkd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   freq_hz,
    output logic          busy,
    output logic          done,
    output logic [7:0]    div_reg,
    output logic [7:0]    code_reg,
    output logic [7:0]    ctl_reg
);

    localparam logic [DW-1:0] K_KHZ   = DW'(HZ_PER_KHZ);
    localparam logic [DW-1:0] K_NUMER = DW'(TGT_NUMER);
    localparam logic [DW-1:0] K_ROUND = DW'(ROUND_ADD);

    lkd_state_e state_q, state_nx;

    logic [DW-1:0]     freq_q;
    logic [1:0]        shift_q;
    logic [1:0]        shift_sel;
    logic [DW-1:0]     khz_q;
    logic [DW-1:0]     tgt_q;
    logic [CODE_W-1:0] code_q;

    logic              dv_start;
    logic [DW-1:0]     dv_dividend;
    logic [DW-1:0]     dv_divisor;
    logic              dv_busy;
    logic              dv_done;
    logic [DW-1:0]     dv_quo;

    lkd_band_sel #(.FW(DW)) u_band (
        .freq       (DW'(freq_hz)),
        .shift_log2 (shift_sel)
    );

    lkd_serial_div #(.W(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dv_start),
        .dividend (dv_dividend),
        .divisor  (dv_divisor),
        .busy     (dv_busy),
        .done     (dv_done),
        .quotient (dv_quo)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_nx = ST_KHZ_GO;
            ST_KHZ_GO:   state_nx = ST_KHZ_RUN;
            ST_KHZ_RUN:  if (dv_done) state_nx = ST_TGT_GO;
            ST_TGT_GO:   state_nx = ST_TGT_RUN;
            ST_TGT_RUN:  if (dv_done) state_nx = ST_CODE_GO;
            ST_CODE_GO:  state_nx = ST_CODE_RUN;
            ST_CODE_RUN: if (dv_done) state_nx = ST_PACK;
            ST_PACK:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Divider operand selection per stage
    always_comb begin
        dv_start    = 1'b0;
        dv_dividend = '0;
        dv_divisor  = K_KHZ;
        unique case (state_q)
            ST_KHZ_GO: begin
                dv_start    = 1'b1;
                dv_dividend = freq_q >> shift_q;
                dv_divisor  = K_KHZ;
            end
            ST_TGT_GO: begin
                dv_start    = 1'b1;
                dv_dividend = K_NUMER;
                dv_divisor  = khz_q;
            end
            ST_CODE_GO: begin
                dv_start    = 1'b1;
                dv_dividend = (tgt_q << 4) + (tgt_q << 3) + K_ROUND;
                dv_divisor  = K_KHZ;
            end
            default: begin
                dv_start    = 1'b0;
            end
        endcase
    end

    // Outputs and stage results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q   <= '0;
            shift_q  <= '0;
            khz_q    <= '0;
            tgt_q    <= '0;
            code_q   <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            div_reg  <= '0;
            code_reg <= '0;
            ctl_reg  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        freq_q  <= DW'(freq_hz);
                        shift_q <= shift_sel;
                        busy    <= 1'b1;
                    end
                end
                ST_KHZ_RUN: begin
                    if (dv_done) khz_q <= dv_quo;
                end
                ST_TGT_RUN: begin
                    if (dv_done) tgt_q <= dv_quo;
                end
                ST_CODE_RUN: begin
                    if (dv_done) code_q <= dv_quo[CODE_W-1:0];
                end
                ST_PACK: begin
                    div_reg  <= {2'b00, shift_q, 4'b0000};
                    code_reg <= code_q[7:0];
                    ctl_reg  <= {CTL_TOL, CTL_REPEAT, code_q[8]};
                    busy     <= 1'b0;
                    done     <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/lkd_code_gen_checker.sv
module lkd_code_gen_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] div_reg,
    input logic [7:0] code_reg,
    input logic [7:0] ctl_reg
);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_images_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(div_reg) && $stable(code_reg) && $stable(ctl_reg)));

    assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_div_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_reg[7:6] == 2'b00 && div_reg[3:0] == 4'b0000));

    assert_ctl_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctl_reg[7:4] == 4'd2 && ctl_reg[3:1] == 3'd2));

endmodule

bind lkd_code_gen lkd_code_gen_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .div_reg  (div_reg),
    .code_reg (code_reg),
    .ctl_reg  (ctl_reg)
);

// File: tb/lkd_code_gen_bench.sv
module lkd_code_gen_bench;

    localparam int DW    = 32;
    localparam int LAT   = 3 * (DW + 2) + 2; // negedges from start drive to done seen (R9)
    localparam int NVEC  = 12;

    // frequency, expected log2 pre-divider
    localparam logic [31:0] VF [NVEC] = '{
        32'd22_250_000, 32'd47_500_000, 32'd48_000_000, 32'd50_349_650,
        32'd74_250_000, 32'd99_000_000, 32'd100_000_000, 32'd100_699_300,
        32'd198_000_000, 32'd200_000_000, 32'd205_000_000, 32'd297_000_000
    };
    localparam logic [1:0] VS [NVEC] = '{
        2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd0, 2'd2, 2'd2, 2'd0, 2'd3, 2'd3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] freq_hz = '0;
    logic        busy, done;
    logic [7:0]  div_reg, code_reg, ctl_reg;

    int checks = 0;
    int errors = 0;
    bit timed_out = 1'b0;

    always #5 clk = ~clk;

    lkd_code_gen #(.DW(DW)) u_lkd_code_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .freq_hz  (freq_hz),
        .busy     (busy),
        .done     (done),
        .div_reg  (div_reg),
        .code_reg (code_reg),
        .ctl_reg  (ctl_reg)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned exp_code(input longint f, input int sh);
        longint khz, tgt;
        khz = (f >> sh) / 1000;
        tgt = 256_000_000 / khz;
        return int'(((tgt * 24) + 999) / 1000) & 'h1ff;
    endfunction

    // Drives start at a negedge and returns negedges counted until done is seen
    task automatic run(input logic [31:0] f, output int n);
        freq_hz = f;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        n = 1;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_result(input logic [31:0] f, input logic [1:0] sh, input string tag);
        int unsigned c;
        c = exp_code(longint'(f), int'(sh));
        chk({tag, " R1 div_reg"}, div_reg, {2'b00, sh, 4'b0000});
        chk({tag, " R2 R3 R4 code_reg"}, code_reg, c & 'hff);
        chk({tag, " R4 R5 ctl_reg"}, ctl_reg, 8'h24 | ((c >> 8) & 1));
    endtask

    initial begin
        #2_000_000;
        timed_out = 1'b1;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 busy", busy, 0);
        chk("R8 done", done, 0);
        chk("R8 images", {div_reg, code_reg, ctl_reg}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run(VF[i], n);
            chk("R6 done seen", done, 1);
            chk("R6 busy low with done", busy, 0);
            check_result(VF[i], VS[i], $sformatf("vec%0d", i));
            @(negedge clk);
            chk("R6 done one cycle", done, 0);
            if (timed_out) break;
        end

        // R9 latency and R6 busy on the cycle after start
        freq_hz = 32'd74_250_000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy after start", busy, 1);
        n = 1;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R9 latency", n, LAT);
        // known values for 74.25 MHz: code 166
        chk("R3 code 74.25MHz", code_reg, 8'hA6);
        chk("R1 div 74.25MHz", div_reg, 8'h10);
        @(negedge clk);

        // R7 restart while busy is ignored
        freq_hz = 32'd297_000_000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        freq_hz = 32'd22_250_000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 12;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R7 latency unchanged", n, LAT);
        check_result(32'd297_000_000, 2'd3, "R7 first request kept");
        begin
            int extra = 0;
            for (int k = 0; k < LAT + 10; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R7 no extra done", extra, 0);
        end
        chk("R7 idle", busy, 0);

        // R4 bit 8: 22.25 MHz gives code 277
        run(32'd22_250_000, n);
        chk("R4 code low", code_reg, 8'h15);
        chk("R4 bit8", ctl_reg, 8'h25);

        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule